// File: doc/BRIEF.md
# 128-bit Half Select and Insert Unit

This block assembles a 256-bit vector out of 128-bit halves. It has three operations. The half permute fills each half of the result with any one of the four halves held by two 256-bit sources. The insert operation writes a 128-bit operand into one half of the result and takes the other half from the first source. The extract operation copies one half of the first source onto a separate 128-bit output.

A command is presented for one cycle with `in_valid` high. It carries both sources, the insert operand, an 8-bit immediate and a 2-bit operation code. The selected outputs are registered and appear one cycle later with `out_valid` high. Every selection reads the inputs that are sampled in the strobe cycle. The register that receives the result can therefore be fed back as a source in the next command and still give a correct result.

Top module: `half_lane_xbar`

## Requirements
- R1: After reset, `out_valid` is 0, `result` is all zeros and `extract` is all zeros.
- R2: The half permute uses operation code 0. `imm[1:0]` selects `result[127:0]`. Code 0 selects `src_a[127:0]`, code 1 selects `src_a[255:128]`, code 2 selects `src_b[127:0]` and code 3 selects `src_b[255:128]`.
- R3: For the half permute, `imm[5:4]` selects `result[255:128]` from the same four halves with the same code values as R2.
- R4: Insert uses operation code 1. When `imm[0]` is 0, `ins_data` is written to `result[127:0]` and `result[255:128]` is set to `src_a[255:128]`. When `imm[0]` is 1, `ins_data` is written to `result[255:128]` and `result[127:0]` is set to `src_a[127:0]`.
- R5: Extract uses operation code 2. `extract` is set to `src_a[127:0]` when `imm[0]` is 0 and to `src_a[255:128]` when `imm[0]` is 1.
- R6: Some immediate bits have no effect on any output: bits 7:6 and 3:2 for the half permute, and bits 7:1 for insert and extract.
- R7: The output registers change only in the cycle after `in_valid` is high. `out_valid` is high exactly in the cycle after each `in_valid` strobe.
- R8: An extract leaves `result` unchanged. A permute or an insert leaves `extract` unchanged. Operation code 3 leaves both unchanged but still raises `out_valid`.
- R9: Strobes on consecutive cycles each produce their own result. A command whose `src_a` is the previous `result` builds its output from that earlier value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Command strobe |
| op | input | 2 | Operation: 0 permute, 1 insert, 2 extract, 3 none |
| imm | input | 8 | Immediate with the selector fields |
| src_a | input | 256 | First source vector |
| src_b | input | 256 | Second source vector |
| ins_data | input | 128 | Operand for insert |
| out_valid | output | 1 | High one cycle after a strobe |
| result | output | 256 | Registered 256-bit result |
| extract | output | 128 | Registered extracted half |

## Verification
The embedded properties check the following on every cycle: the one-cycle valid timing and the holding of outputs between strobes (R7), insert placement (R4), extract selection (R5), and the independence of the two output registers (R8). The bench's behavioural model is compared on every clock. It alone shows all sixteen half-permute code pairs (R2, R3) and that random values in the ignored immediate bits change nothing (R6). It also covers back-to-back strobes whose first source is the previous result (R9) and the reset values (R1).

// File: rtl/half_lane_xbar.sv
module half_lane_xbar #(
  parameter int HALF_W = 128,
  localparam int VEC_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        op,
  input  logic [7:0]        imm,
  input  logic [VEC_W-1:0]  src_a,
  input  logic [VEC_W-1:0]  src_b,
  input  logic [HALF_W-1:0] ins_data,
  output logic              out_valid,
  output logic [VEC_W-1:0]  result,
  output logic [HALF_W-1:0] extract
);

  localparam logic [1:0] OP_PERM = 2'd0;
  localparam logic [1:0] OP_INS  = 2'd1;
  localparam logic [1:0] OP_EXT  = 2'd2;

  wire [HALF_W-1:0] a_lo = src_a[HALF_W-1:0];
  wire [HALF_W-1:0] a_hi = src_a[VEC_W-1:HALF_W];
  wire [HALF_W-1:0] b_lo = src_b[HALF_W-1:0];
  wire [HALF_W-1:0] b_hi = src_b[VEC_W-1:HALF_W];

  function automatic logic [HALF_W-1:0] pick(input logic [1:0] sel,
                                             input logic [HALF_W-1:0] p0, p1, p2, p3);
    case (sel)
      2'd0:    pick = p0;
      2'd1:    pick = p1;
      2'd2:    pick = p2;
      default: pick = p3;
    endcase
  endfunction

  wire [HALF_W-1:0] perm_lo = pick(imm[1:0], a_lo, a_hi, b_lo, b_hi);
  wire [HALF_W-1:0] perm_hi = pick(imm[5:4], a_lo, a_hi, b_lo, b_hi);

  logic [VEC_W-1:0]  res_n;
  logic [HALF_W-1:0] ext_n;

  always_comb begin
    res_n = result;
    ext_n = extract;
    case (op)
      OP_PERM: res_n = {perm_hi, perm_lo};
      OP_INS:  res_n = imm[0] ? {ins_data, a_lo} : {a_hi, ins_data};
      OP_EXT:  ext_n = imm[0] ? a_hi : a_lo;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      extract   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= res_n;
        extract <= ext_n;
      end
    end
  end

  p_valid_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(extract)));
  p_ext_keeps_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_EXT) |=> $stable(result));
  p_vec_ops_keep_ext_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op == OP_PERM || op == OP_INS)) |=> $stable(extract));
  p_insert_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_INS && !imm[0]) |=>
      (result[HALF_W-1:0] == $past(ins_data) &&
       result[VEC_W-1:HALF_W] == $past(src_a[VEC_W-1:HALF_W])));
  p_insert_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_INS && imm[0]) |=>
      (result[VEC_W-1:HALF_W] == $past(ins_data) &&
       result[HALF_W-1:0] == $past(src_a[HALF_W-1:0])));
  p_extract_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_EXT) |=>
      (extract == ($past(imm[0]) ? $past(src_a[VEC_W-1:HALF_W]) : $past(src_a[HALF_W-1:0]))));

endmodule

// File: tb/half_lane_xbar_bench.sv
`timescale 1ns/1ps
module half_lane_xbar_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [1:0]   op = 2'd0;
  logic [7:0]   imm = 8'd0;
  logic [255:0] src_a = '0;
  logic [255:0] src_b = '0;
  logic [127:0] ins_data = '0;
  logic         out_valid;
  logic [255:0] result;
  logic [127:0] extract;

  int checks = 0;
  int errors = 0;
  bit enable_cmp = 1'b0;
  string cur_tag = "R7";
  string exp_tag = "R7";

  logic         exp_valid = 1'b0;
  logic [255:0] exp_res = '0;
  logic [127:0] exp_ext = '0;

  always #2 clk = ~clk;

  half_lane_xbar u_half_lane_xbar (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .imm(imm),
    .src_a(src_a), .src_b(src_b), .ins_data(ins_data),
    .out_valid(out_valid), .result(result), .extract(extract)
  );

  function automatic logic [127:0] quarter(input int code, input logic [255:0] a, input logic [255:0] b);
    if (code == 0) return a[127:0];
    if (code == 1) return a[255:128];
    if (code == 2) return b[127:0];
    return b[255:128];
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      exp_valid <= in_valid;
      if (in_valid) begin
        exp_tag <= cur_tag;
        if (op == 2'd0)
          exp_res <= {quarter(int'(imm[5:4]), src_a, src_b), quarter(int'(imm[1:0]), src_a, src_b)};
        else if (op == 2'd1)
          exp_res <= imm[0] ? {ins_data, src_a[127:0]} : {src_a[255:128], ins_data};
        else if (op == 2'd2)
          exp_ext <= imm[0] ? src_a[255:128] : src_a[127:0];
      end else begin
        exp_tag <= "R7";
      end
    end
  end

  task automatic check(input string tag, input string what, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (enable_cmp) begin
      check(exp_tag, "out_valid", {255'd0, out_valid}, {255'd0, exp_valid});
      check(exp_tag, "result", result, exp_res);
      check(exp_tag, "extract", {128'd0, extract}, {128'd0, exp_ext});
    end
  end

  function automatic logic [255:0] rnd256();
    return {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic issue(input string tag, input logic [1:0] o, input logic [7:0] i,
                       input logic [255:0] a, input logic [255:0] b, input logic [127:0] d);
    @(negedge clk);
    cur_tag = tag; in_valid = 1'b1; op = o; imm = i; src_a = a; src_b = b; ins_data = d;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      cur_tag = "R7"; in_valid = 1'b0;
      src_a = rnd256(); src_b = rnd256(); ins_data = rnd256()[127:0]; imm = 8'($urandom);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    check("R1", "out_valid", {255'd0, out_valid}, 256'd0);
    check("R1", "result", result, 256'd0);
    check("R1", "extract", {128'd0, extract}, 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    enable_cmp = 1'b1;

    // R2 R3 all selector pairs, ignored bits clear
    for (int lo = 0; lo < 4; lo++)
      for (int hi = 0; hi < 4; hi++)
        issue("R2 R3", 2'd0, {2'b00, 2'(hi), 2'b00, 2'(lo)}, rnd256(), rnd256(), rnd256()[127:0]);
    idle(2);

    // R4 insert both halves
    issue("R4", 2'd1, 8'h00, rnd256(), rnd256(), rnd256()[127:0]);
    idle(1);
    issue("R4", 2'd1, 8'h01, rnd256(), rnd256(), rnd256()[127:0]);
    idle(1);

    // R5 R8 extract both halves; result must stay
    issue("R5 R8", 2'd2, 8'h00, rnd256(), rnd256(), rnd256()[127:0]);
    issue("R5 R8", 2'd2, 8'h01, rnd256(), rnd256(), rnd256()[127:0]);
    idle(1);

    // R8 code 3 changes nothing but raises valid
    issue("R8", 2'd3, 8'hff, rnd256(), rnd256(), rnd256()[127:0]);
    idle(1);

    // R6 random ignored bits
    for (int k = 0; k < 40; k++)
      issue("R6", 2'($urandom_range(0, 2)), 8'($urandom), rnd256(), rnd256(), rnd256()[127:0]);
    idle(3);

    // R7 long idle with moving inputs
    idle(10);

    // R9 back-to-back with previous result fed back as first source
    issue("R9", 2'd0, 8'h21, rnd256(), rnd256(), rnd256()[127:0]);
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      cur_tag = "R9"; in_valid = 1'b1; op = 2'($urandom_range(0, 2)); imm = 8'($urandom);
      src_a = exp_res; src_b = rnd256(); ins_data = rnd256()[127:0];
    end
    idle(3);

    // mixed random traffic
    for (int k = 0; k < 300; k++) begin
      if ($urandom_range(0, 3) == 0) idle(1);
      else issue("R2 R4 R5 R8", 2'($urandom), 8'($urandom), rnd256(), rnd256(), rnd256()[127:0]);
    end
    idle(3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule